// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block keeps one pending-write bit per architectural register of a single register file. It serves an in-order issue controller that feeds several function units. When an instruction is issued with a destination, the matching bit is raised one clock after the issue event. This means the issuing instruction is never held up by its own destination. The bit is lowered in either of two cases: a write port commits a result to that register, or the unit that owns the write finishes without producing a result. Set and clear requests from every write port and every unit are merged before the vector is updated. A set wins over a clear on the same bit.

The controller presents the source and destination numbers of the next instruction. The block answers with a read hazard flag (a pending source) and a write hazard flag (a pending destination). Issue is withheld while the write hazard flag is high. Once the unit that asked has gone busy and saw no hazard, its read check is released, so that its own later pending bits cannot stall it.

Two build options are available. Register numbers can be binary or already one-hot. The whole file can also be folded to a single pending bit, so that any access to it conflicts with any outstanding write.

Each unit has a small tracker state machine with two states:
- `TRK_IDLE`: no write owed.
- `TRK_ARMED`: a write is owed.

Its transitions are:
- IDLE to ARMED on issue with the write flag set.
- ARMED to ARMED on a new issue with the write flag set.
- ARMED to IDLE in three cases: a new issue without the write flag; completion without a result, which also clears the latched mask; or the unit no longer being busy.

The query gate also has two states:
- `GATE_OPEN`: hazards pass through.
- `GATE_SHUT`: the read hazard is forced low.

Its transitions are:
- OPEN to SHUT when the owner is busy and no read hazard is seen.
- SHUT to OPEN when the owner is no longer busy.

Top module: `hz_scoreboard`

## Requirements
- R1: An issue with the write flag set raises the destination's pending bit at the second rising edge after the issue cycle, not the first. A query in the cycle right after issue therefore sees no hazard against that destination. An issue with the write flag clear raises nothing.
- R2: A commit on any write port clears the pending bit of its register at the next edge.
- R3: On issue, a unit tracker latches the destination mask when the write flag is set. The latch is dropped in the first cycle the unit is not busy. If the unit signals done with result-valid low while the latch is held, the latched bit is cleared at that edge. Done with result-valid high clears nothing. Done after the latch was dropped clears nothing.
- R4: With ONEHOT=0 a register number n selects bit n (mask = 1 << n). With ONEHOT=1 the number is used directly as the mask. The pending vector is identical in both cases.
- R5: Clear masks from all write ports and all unit trackers are OR-merged. Two ports committing different registers in the same cycle clear both.
- R6: The read hazard is the OR over sources of (pending vector AND source mask). A source with its enable bit low contributes nothing.
- R7: Suppose the query owner is busy and the read hazard is low in a cycle. Then the read hazard is forced low from the next edge until the edge after the owner's busy input falls. If a hazard was seen, it is still reported while the owner is busy.
- R8: The write hazard is high exactly when the enabled query destination's bit is pending.
- R9: With FOLD=1 the pending vector is one bit wide. Any issued destination sets it, any commit clears it, and any enabled source or destination sees it.
- R10: When a delayed set and a clear target the same bit at the same edge, the bit ends up set.
- R11: A synchronous reset clears the whole pending vector. Both hazard outputs then read low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_fire | input | 1 | Issue event this cycle |
| iss_fu | input | UNIT_W | Unit receiving the issued instruction |
| iss_dst | input | IDX_W | Destination register number of the issue |
| iss_dst_en | input | 1 | Issued instruction writes a register |
| cmt_fire | input | NUM_WR_PORTS | Per-port commit strobe |
| cmt_dst | input | NUM_WR_PORTS*IDX_W | Per-port committed register number, port p at bits [p*IDX_W +: IDX_W] |
| fu_busy | input | NUM_UNITS | Per-unit busy |
| fu_done | input | NUM_UNITS | Per-unit completion strobe |
| fu_res_ok | input | NUM_UNITS | Per-unit result-valid at completion |
| qry_src | input | NUM_SRC*IDX_W | Source register numbers of the queried instruction |
| qry_src_en | input | NUM_SRC | Per-source read enable |
| qry_dst | input | IDX_W | Destination register number of the queried instruction |
| qry_dst_en | input | 1 | Queried instruction writes a register |
| qry_owner_busy | input | 1 | Unit holding the queried instruction is busy |
| pend_vec | output | PEND_W | Registered pending-write vector |
| raw_hz | output | 1 | Read-after-write hazard |
| waw_hz | output | 1 | Write-after-write hazard, withholds issue |

## Verification
Two functions can fall in the same cycle and act on the same bit: the delayed set left by an issue, and a clear from a write port. To provoke this, the bench issues a register and then commits that same register in the very next cycle. It judges the outcome by requiring the bit to remain pending. A second collision comes from two write ports committing different registers at the same edge. That case is judged by requiring both bits to be gone, with neither port masking the other. The bench also sweeps every register against every query number, and compares the binary, one-hot and folded builds against arithmetically derived masks.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

    typedef enum logic [0:0] {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;

    typedef enum logic [0:0] {
        GATE_OPEN = 1'b0,
        GATE_SHUT = 1'b1
    } gate_state_e;

endpackage

// File: rtl/hz_mask_conv.sv
`timescale 1ns/1ps
module hz_mask_conv #(
    parameter int NUM_REGS = 8,
    parameter bit ONEHOT   = 1'b0,
    parameter bit FOLD     = 1'b0,
    localparam int IDX_W   = ONEHOT ? NUM_REGS : $clog2(NUM_REGS),
    localparam int PEND_W  = FOLD ? 1 : NUM_REGS
) (
    input  logic [IDX_W-1:0]  num_i,
    input  logic              en_i,
    output logic [PEND_W-1:0] mask_o
);

    logic [NUM_REGS-1:0] full_mask;

    generate
        if (ONEHOT) begin : g_pass
            assign full_mask = en_i ? num_i : '0;
        end else begin : g_decode
            assign full_mask = en_i ? (NUM_REGS'(1) << num_i) : '0;
        end

        if (FOLD) begin : g_fold
            assign mask_o = |full_mask;
        end else begin : g_wide
            assign mask_o = full_mask;
        end
    endgenerate

endmodule

// File: rtl/hz_unit_track.sv
`timescale 1ns/1ps
module hz_unit_track
    import hz_pkg::*;
#(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic              dst_en_i,
    input  logic [PEND_W-1:0] dst_mask_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              res_ok_i,
    output logic [PEND_W-1:0] clr_o
);

    trk_state_e        state_q, state_d;
    logic [PEND_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TRK_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                        mask_q <= '0;
        else if (issue_i && dst_en_i)   mask_q <= dst_mask_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (issue_i && dst_en_i) state_d = TRK_ARMED;
            end
            TRK_ARMED: begin
                if (issue_i && dst_en_i)        state_d = TRK_ARMED;
                else if (issue_i)               state_d = TRK_IDLE;
                else if (done_i && !res_ok_i)   state_d = TRK_IDLE;
                else if (!busy_i)               state_d = TRK_IDLE;
            end
        endcase
    end

    always_comb begin
        clr_o = '0;
        unique case (state_q)
            TRK_IDLE:  clr_o = '0;
            TRK_ARMED: if (done_i && !res_ok_i) clr_o = mask_q;
        endcase
    end

    AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (rst)
        ((clr_o != '0) && !issue_i) |=> (state_q == TRK_IDLE)); // R3

endmodule

// File: rtl/hz_query_gate.sv
`timescale 1ns/1ps
module hz_query_gate
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic owner_busy_i,
    input  logic hz_raw_i,
    output logic hz_o
);

    gate_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        hz_o    = 1'b0;
        unique case (state_q)
            GATE_OPEN: begin
                hz_o = hz_raw_i;
                if (owner_busy_i && !hz_raw_i) state_d = GATE_SHUT;
            end
            GATE_SHUT: begin
                hz_o = 1'b0;
                if (!owner_busy_i) state_d = GATE_OPEN;
            end
        endcase
    end

    AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (owner_busy_i && !hz_o) |=> (!owner_busy_i || !hz_o)); // R7

endmodule

// File: rtl/hz_scoreboard.sv
`timescale 1ns/1ps
module hz_scoreboard #(
    parameter int NUM_REGS     = 8,
    parameter int NUM_WR_PORTS = 2,
    parameter int NUM_UNITS    = 2,
    parameter int NUM_SRC      = 2,
    parameter bit ONEHOT       = 1'b0,
    parameter bit FOLD         = 1'b0,
    localparam int IDX_W       = ONEHOT ? NUM_REGS : $clog2(NUM_REGS),
    localparam int PEND_W      = FOLD ? 1 : NUM_REGS,
    localparam int UNIT_W      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          iss_fire,
    input  logic [UNIT_W-1:0]             iss_fu,
    input  logic [IDX_W-1:0]              iss_dst,
    input  logic                          iss_dst_en,
    input  logic [NUM_WR_PORTS-1:0]       cmt_fire,
    input  logic [NUM_WR_PORTS*IDX_W-1:0] cmt_dst,
    input  logic [NUM_UNITS-1:0]          fu_busy,
    input  logic [NUM_UNITS-1:0]          fu_done,
    input  logic [NUM_UNITS-1:0]          fu_res_ok,
    input  logic [NUM_SRC*IDX_W-1:0]      qry_src,
    input  logic [NUM_SRC-1:0]            qry_src_en,
    input  logic [IDX_W-1:0]              qry_dst,
    input  logic                          qry_dst_en,
    input  logic                          qry_owner_busy,
    output logic [PEND_W-1:0]             pend_vec,
    output logic                          raw_hz,
    output logic                          waw_hz
);

    logic [PEND_W-1:0] iss_mask;
    logic [PEND_W-1:0] qdst_mask;
    logic [PEND_W-1:0] cmt_mask [NUM_WR_PORTS];
    logic [PEND_W-1:0] src_mask [NUM_SRC];
    logic [PEND_W-1:0] trk_clr  [NUM_UNITS];
    logic [PEND_W-1:0] clr_all;
    logic [PEND_W-1:0] src_all;
    logic [PEND_W-1:0] set_d;
    logic [PEND_W-1:0] pend_q;
    logic              raw_pre;

    hz_mask_conv #(.NUM_REGS(NUM_REGS), .ONEHOT(ONEHOT), .FOLD(FOLD)) u_iss_conv (
        .num_i(iss_dst), .en_i(iss_fire && iss_dst_en), .mask_o(iss_mask));

    hz_mask_conv #(.NUM_REGS(NUM_REGS), .ONEHOT(ONEHOT), .FOLD(FOLD)) u_qdst_conv (
        .num_i(qry_dst), .en_i(qry_dst_en), .mask_o(qdst_mask));

    generate
        for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_port
            hz_mask_conv #(.NUM_REGS(NUM_REGS), .ONEHOT(ONEHOT), .FOLD(FOLD)) u_cmt_conv (
                .num_i(cmt_dst[p*IDX_W +: IDX_W]), .en_i(cmt_fire[p]),
                .mask_o(cmt_mask[p]));
        end

        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            hz_mask_conv #(.NUM_REGS(NUM_REGS), .ONEHOT(ONEHOT), .FOLD(FOLD)) u_src_conv (
                .num_i(qry_src[s*IDX_W +: IDX_W]), .en_i(qry_src_en[s]),
                .mask_o(src_mask[s]));
        end

        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            hz_unit_track #(.PEND_W(PEND_W)) u_track (
                .clk(clk), .rst(rst),
                .issue_i(iss_fire && (iss_fu == UNIT_W'(u))),
                .dst_en_i(iss_dst_en), .dst_mask_i(iss_mask),
                .busy_i(fu_busy[u]), .done_i(fu_done[u]), .res_ok_i(fu_res_ok[u]),
                .clr_o(trk_clr[u]));
        end
    endgenerate

    // merge every clear source; no port or unit overrides another
    always_comb begin
        clr_all = '0;
        for (int p = 0; p < NUM_WR_PORTS; p++) clr_all = clr_all | cmt_mask[p];
        for (int u = 0; u < NUM_UNITS; u++)    clr_all = clr_all | trk_clr[u];
    end

    always_comb begin
        src_all = '0;
        for (int s = 0; s < NUM_SRC; s++) src_all = src_all | src_mask[s];
    end

    // issue mask is held one cycle before it reaches the vector
    always_ff @(posedge clk) begin
        if (rst) set_d <= '0;
        else     set_d <= iss_mask;
    end

    // set has priority over clear on a shared bit
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_all) | set_d;
    end

    assign raw_pre  = |(pend_q & src_all);
    assign waw_hz   = |(pend_q & qdst_mask);
    assign pend_vec = pend_q;

    hz_query_gate u_gate (
        .clk(clk), .rst(rst),
        .owner_busy_i(qry_owner_busy), .hz_raw_i(raw_pre), .hz_o(raw_hz));

    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst)
        (iss_fire && iss_dst_en && (set_d == '0) && (clr_all == '0))
        |=> (pend_vec == $past(pend_vec))); // R1

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        ((clr_all & ~set_d) != '0) |=> ((pend_vec & $past(clr_all & ~set_d)) == '0)); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_d != '0) |=> ((pend_vec & $past(set_d)) == $past(set_d))); // R10

    AST_RAW_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
        (qry_src_en == '0) |-> !raw_hz); // R6

    AST_WAW_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        (pend_vec == '0) |-> !waw_hz); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (pend_vec == '0)); // R11

endmodule

// File: tb/hz_scoreboard_tb_top.sv
`timescale 1ns/1ps
module hz_scoreboard_tb_top;

    localparam int NR = 8;
    localparam int IW = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_fire, iss_fu, iss_dst_en;
    logic [2:0] iss_dst;
    logic [1:0] cmt_fire;
    logic [5:0] cmt_dst;
    logic [1:0] fu_busy, fu_done, fu_res_ok;
    logic [5:0] qry_src;
    logic [1:0] qry_src_en;
    logic [2:0] qry_dst;
    logic       qry_dst_en, qry_owner_busy;

    logic [7:0]  pend;
    logic        raw, waw;
    logic [0:0]  f_pend;
    logic        f_raw, f_waw;
    logic [7:0]  o_pend;
    logic        o_raw, o_waw;
    logic [7:0]  oh_iss_dst, oh_qry_dst;
    logic [15:0] oh_cmt_dst, oh_qry_src;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    assign oh_iss_dst = 8'(1) << iss_dst;
    assign oh_qry_dst = 8'(1) << qry_dst;
    assign oh_cmt_dst = {8'(1) << cmt_dst[5:3], 8'(1) << cmt_dst[2:0]};
    assign oh_qry_src = {8'(1) << qry_src[5:3], 8'(1) << qry_src[2:0]};

    hz_scoreboard dut_i (
        .clk(clk), .rst(rst), .iss_fire(iss_fire), .iss_fu(iss_fu),
        .iss_dst(iss_dst), .iss_dst_en(iss_dst_en), .cmt_fire(cmt_fire),
        .cmt_dst(cmt_dst), .fu_busy(fu_busy), .fu_done(fu_done),
        .fu_res_ok(fu_res_ok), .qry_src(qry_src), .qry_src_en(qry_src_en),
        .qry_dst(qry_dst), .qry_dst_en(qry_dst_en),
        .qry_owner_busy(qry_owner_busy), .pend_vec(pend), .raw_hz(raw),
        .waw_hz(waw));

    hz_scoreboard #(.FOLD(1'b1)) dut_fold_i (
        .clk(clk), .rst(rst), .iss_fire(iss_fire), .iss_fu(iss_fu),
        .iss_dst(iss_dst), .iss_dst_en(iss_dst_en), .cmt_fire(cmt_fire),
        .cmt_dst(cmt_dst), .fu_busy(fu_busy), .fu_done(fu_done),
        .fu_res_ok(fu_res_ok), .qry_src(qry_src), .qry_src_en(qry_src_en),
        .qry_dst(qry_dst), .qry_dst_en(qry_dst_en),
        .qry_owner_busy(qry_owner_busy), .pend_vec(f_pend), .raw_hz(f_raw),
        .waw_hz(f_waw));

    hz_scoreboard #(.ONEHOT(1'b1)) dut_oh_i (
        .clk(clk), .rst(rst), .iss_fire(iss_fire), .iss_fu(iss_fu),
        .iss_dst(oh_iss_dst), .iss_dst_en(iss_dst_en), .cmt_fire(cmt_fire),
        .cmt_dst(oh_cmt_dst), .fu_busy(fu_busy), .fu_done(fu_done),
        .fu_res_ok(fu_res_ok), .qry_src(oh_qry_src), .qry_src_en(qry_src_en),
        .qry_dst(oh_qry_dst), .qry_dst_en(qry_dst_en),
        .qry_owner_busy(qry_owner_busy), .pend_vec(o_pend), .raw_hz(o_raw),
        .waw_hz(o_waw));

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_query();
        qry_src = '0; qry_src_en = '0; qry_dst = '0; qry_dst_en = 1'b0;
        #1;
    endtask

    task automatic issue(input logic fu, input int r, input logic wr);
        iss_fire = 1'b1; iss_fu = fu; iss_dst = r[2:0]; iss_dst_en = wr;
        step();
        iss_fire = 1'b0; iss_dst_en = 1'b0;
    endtask

    task automatic commit_one(input int port, input int r);
        cmt_fire = '0;
        cmt_fire[port] = 1'b1;
        cmt_dst[port*IW +: IW] = r[2:0];
        step();
        cmt_fire = '0;
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        iss_fire = 0; iss_fu = 0; iss_dst = 0; iss_dst_en = 0;
        cmt_fire = 0; cmt_dst = 0; fu_busy = 0; fu_done = 0; fu_res_ok = 0;
        qry_src = 0; qry_src_en = 0; qry_dst = 0; qry_dst_en = 0;
        qry_owner_busy = 0;
        repeat (3) step();
        rst = 1'b0;
        #1;
        chk("R11 reset pending", 32'(pend), 0);
        chk("R11 reset raw", 32'(raw), 0);
        chk("R11 reset waw", 32'(waw), 0);

        // sweep every destination against every query number
        for (int r = 0; r < NR; r++) begin
            issue(1'b0, r, 1'b1);
            qry_src[2:0] = r[2:0]; qry_src_en = 2'b01;
            qry_dst = r[2:0]; qry_dst_en = 1'b1;
            #1;
            chk("R1 not set after first edge", 32'(pend), 0);
            chk("R1 no self raw", 32'(raw), 0);
            chk("R1 no self waw", 32'(waw), 0);
            clear_query();
            step();
            chk("R1 set after second edge", 32'(pend), 32'(1) << r);
            chk("R4 onehot build matches", 32'(o_pend), 32'(1) << r);
            chk("R9 folded bit set", 32'(f_pend), 1);
            for (int q = 0; q < NR; q++) begin
                int slot = q & 1;
                qry_src = '0;
                qry_src[slot*IW +: IW] = q[2:0];
                qry_src_en = 2'(1 << slot);
                qry_dst = q[2:0]; qry_dst_en = 1'b1;
                #1;
                chk("R6 raw per source", 32'(raw), (q == r) ? 1 : 0);
                chk("R8 waw per dest", 32'(waw), (q == r) ? 1 : 0);
                chk("R4 onehot raw", 32'(o_raw), (q == r) ? 1 : 0);
                chk("R9 folded raw", 32'(f_raw), 1);
                chk("R9 folded waw", 32'(f_waw), 1);
                qry_src_en = 2'b00; qry_dst_en = 1'b0;
                #1;
                chk("R6 disabled source ignored", 32'(raw), 0);
                chk("R8 disabled dest ignored", 32'(waw), 0);
            end
            clear_query();
            commit_one(r & 1, r);
            chk("R2 commit clears", 32'(pend), 0);
            chk("R9 folded cleared", 32'(f_pend), 0);
            chk("R4 onehot cleared", 32'(o_pend), 0);
        end

        // two ports committing in one cycle
        issue(1'b0, 2, 1'b1);
        issue(1'b0, 5, 1'b1);
        step();
        chk("R5 two pending", 32'(pend), 32'h24);
        cmt_fire = 2'b11; cmt_dst = {3'd5, 3'd2};
        step();
        cmt_fire = '0;
        chk("R5 both ports cleared", 32'(pend), 0);

        // delayed set and commit on the same bit at one edge
        issue(1'b0, 3, 1'b1);
        commit_one(0, 3);
        chk("R10 set beats clear", 32'(pend), 32'h08);
        commit_one(1, 3);
        chk("R2 later commit clears", 32'(pend), 0);

        // issue without write flag
        issue(1'b0, 2, 1'b0);
        step();
        chk("R1 no write flag no set", 32'(pend), 0);

        // done without writing clears
        fu_busy[1] = 1'b1;
        issue(1'b1, 6, 1'b1);
        step();
        chk("R3 pending before done", 32'(pend), 32'h40);
        fu_done[1] = 1'b1; fu_res_ok[1] = 1'b0;
        step();
        fu_done[1] = 1'b0;
        chk("R3 done without write clears", 32'(pend), 0);
        fu_busy[1] = 1'b0;
        step();

        // done with result keeps the bit
        fu_busy[1] = 1'b1;
        issue(1'b1, 4, 1'b1);
        step();
        fu_done[1] = 1'b1; fu_res_ok[1] = 1'b1;
        step();
        fu_done[1] = 1'b0; fu_res_ok[1] = 1'b0;
        chk("R3 done with result keeps bit", 32'(pend), 32'h10);
        fu_busy[1] = 1'b0;
        step();
        commit_one(0, 4);
        chk("R2 commit after done", 32'(pend), 0);

        // latch dropped once the unit is idle
        issue(1'b1, 7, 1'b1);
        step();
        chk("R3 pending with idle unit", 32'(pend), 32'h80);
        fu_done[1] = 1'b1; fu_res_ok[1] = 1'b0;
        step();
        fu_done[1] = 1'b0;
        chk("R3 dropped latch ignores done", 32'(pend), 32'h80);
        commit_one(1, 7);
        chk("R2 commit after ignored done", 32'(pend), 0);

        // release of the read check once owner is busy and clean
        issue(1'b0, 1, 1'b1);
        step();
        qry_src[2:0] = 3'd1; qry_src_en = 2'b01; qry_owner_busy = 1'b0;
        #1;
        chk("R7 hazard while owner idle", 32'(raw), 1);
        qry_owner_busy = 1'b1;
        step();
        chk("R7 seen hazard still reported", 32'(raw), 1);
        commit_one(0, 1);
        chk("R7 hazard gone after commit", 32'(raw), 0);
        issue(1'b0, 1, 1'b1);
        step();
        chk("R7 pending again", 32'(pend), 32'h02);
        chk("R7 released check silent", 32'(raw), 0);
        qry_owner_busy = 1'b0;
        #1;
        chk("R7 still silent before edge", 32'(raw), 0);
        step();
        chk("R7 reopened after busy falls", 32'(raw), 1);
        clear_query();
        commit_one(0, 1);

        // reset in mid-run
        issue(1'b0, 5, 1'b1);
        step();
        chk("R11 pending before reset", 32'(pend), 32'h20);
        rst = 1'b1;
        step();
        rst = 1'b0;
        qry_dst = 3'd5; qry_dst_en = 1'b1;
        #1;
        chk("R11 reset clears vector", 32'(pend), 0);
        chk("R11 reset clears waw", 32'(waw), 0);
        clear_query();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule